// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps wall-clock time and a calendar date, all stored as packed BCD bytes, so a host can read them and show them without any conversion. A sub-second divider counts pulses from a free-running base oscillator (`osc_pulse`). Every `TICKS_PER_SEC` pulses it issues one tick. The tick advances the seconds field, and carries ripple in the same clock cycle through minutes, hours, date, month and year. The day-of-week field advances whenever the hour wraps through midnight.

The hours byte has its own format bit, which chooses between a 24-hour count and a 12-hour count with a PM flag. The date wraps at the true length of the current month, and February has 29 days in every year whose two-digit value is a multiple of four. A halt flag, kept in the top bit of the seconds byte, freezes the divider and therefore every field.

A host loads any byte through a single-cycle write port. It reads any byte through a combinational read port. Writing the seconds byte also restarts the sub-second divider, so a freshly set time holds for one full second.

Top module: `bcd_rtc_core`

## Requirements
- R1: Byte 0 bits [6:0] count seconds and byte 1 counts minutes, both in packed BCD from 00 to 59. Each tick adds one second. A wrap from 59 to 00 carries into the next field in the same clock cycle.
- R2: Bit 7 of byte 0 is a halt flag. While it is 1, no tick occurs and no field changes, whatever happens on `osc_pulse`. Clearing it lets counting resume.
- R3: Byte 2 with bit 6 = 0 is a 24-hour count 00 to 23 in bits [5:0]. The step from 23 to 00 advances the day.
- R4: Byte 2 with bit 6 = 1 is a 12-hour count 01 to 12 in bits [4:0], with bit 5 = 1 meaning PM. The step from 11 to 12 toggles bit 5, the step from 12 to 01 keeps it, and the step from 11 PM to 12 AM advances the day.
- R5: Byte 4 (date, 01 and up) wraps to 01 after the last day of the month held in byte 5 (01 to 12). Months 04, 06, 09 and 11 have 30 days, month 02 has 29 days when the year is a multiple of four and 28 days otherwise, and all other months have 31 days. Month 12 wraps to 01 and carries into byte 6 (year, 00 to 99), which wraps from 99 to 00.
- R6: Byte 3 (day of week, 1 to 7) increments at each midnight and wraps from 7 to 1.
- R7: A write to byte 0 restarts the divider. The next tick comes exactly `TICKS_PER_SEC` `osc_pulse` cycles after the write cycle.
- R8: Bits that do not belong to a field always read 0: hours bit 7, day-of-week bits [7:3], date bits [7:6] and month bits [7:5]. Writes to those bits are dropped.
- R9: A host write to a byte takes effect even when an increment or a carry reaches the same byte in that cycle.
- R10: After reset the bytes read 00, 00, 00 (24-hour mode), 01, 01, 01, 00 for addresses 0 to 6, with the halt flag clear. Address 7 reads 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_pulse | input | 1 | One base-oscillator pulse, one cycle wide |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Byte address of the write (0 to 6) |
| wr_data | input | 8 | Byte to write |
| rd_addr | input | 3 | Byte address of the read |
| rd_data | output | 8 | Selected byte, combinational |

## Verification
The bench compares every tick of a continuous hour against an arithmetic model, which exercises the seconds and minutes carries across every value. It also loads every hour of both formats one second before the hour steps, which separates the PM toggle at 11 from the plain step from 12 to 1 and finds the true midnight in each format. For every year 00 to 99 and every month it sets the last day at 23:59:59 and ticks once, and it also ticks from February 28. This tells 28, 29, 30 and 31-day months apart and covers the year wrap. Targeted sequences cover the halt flag, the divider restart, a write that collides with a carry, and masked writes of reserved bits.

// File: rtl/rtc_pkg.sv
// Package with shared helpers for the BCD clock calendar.
// Assumes every byte it is given holds valid packed BCD digits.
package rtc_pkg;

    localparam int NUM_FIELDS = 7;

    typedef enum logic [2:0] {
        FLD_SEC  = 3'd0,
        FLD_MIN  = 3'd1,
        FLD_HOUR = 3'd2,
        FLD_DOW  = 3'd3,
        FLD_DATE = 3'd4,
        FLD_MON  = 3'd5,
        FLD_YEAR = 3'd6
    } fld_e;

    // Add one to a two-digit packed BCD value (the caller handles the wrap).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        return (v[3:0] == 4'h9) ? {v[7:4] + 4'h1, 4'h0} : v + 8'h01;
    endfunction

    // A year is a leap year when 10*tens + ones is a multiple of four,
    // which means (2*tens + ones) mod 4 == 0.
    function automatic logic is_leap(input logic [7:0] yr);
        logic [1:0] r;
        r = yr[1:0] + {yr[4], 1'b0};
        return r == 2'b00;
    endfunction

    // Last legal date, in BCD, of a given month and year.
    function automatic logic [7:0] month_last(input logic [7:0] mo, input logic [7:0] yr);
        case (mo)
            8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_subsec_div.sv
// Sub-second divider: turns DIV base pulses into one tick.
// Assumes DIV >= 2. clr restarts the count and suppresses a tick in that cycle.
module rtc_subsec_div #(
    parameter int DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse,
    input  logic halt,
    input  logic clr,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Count base pulses while running; restart on clr.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (clr)              cnt <= '0;
        else if (pulse && !halt)   cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    // Tick on the pulse that completes a second.
    assign tick = pulse && !halt && !clr && (cnt == LAST);

endmodule

// File: rtl/rtc_bcd_wrap.sv
// One packed-BCD field that counts up from LO to a run-time limit hi.
// A write wins over an increment. Bits outside MASK are stored as 0.
module rtc_bcd_wrap
    import rtc_pkg::*;
#(
    parameter logic [7:0] RST  = 8'h00,
    parameter logic [7:0] LO   = 8'h00,
    parameter logic [7:0] MASK = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       inc,
    input  logic [7:0] hi,
    input  logic       wr,
    input  logic [7:0] wr_val,
    output logic [7:0] val,
    output logic       carry
);
    // Hold, load or step the field.
    always_ff @(posedge clk) begin
        if (!rst_n)    val <= RST;
        else if (wr)   val <= wr_val & MASK;
        else if (inc)  val <= (val == hi) ? LO : bcd_inc(val);
    end

    // Pass a carry on when the field wraps.
    assign carry = inc && !wr && (val == hi);

endmodule

// File: rtl/rtc_hour_ctr.sv
// Hours byte: bit 6 picks 12-hour mode, bit 5 is PM (12h) or the twenties digit (24h).
// carry marks the midnight step. Assumes the loaded hour is legal for its mode.
module rtc_hour_ctr
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       inc,
    input  logic       wr,
    input  logic [7:0] wr_val,
    output logic [7:0] hour,
    output logic       carry
);
    logic       mode12;
    logic       pm;
    logic [7:0] nxt;
    logic [7:0] h12;
    logic [7:0] h24;

    assign mode12 = hour[6];
    assign pm     = hour[5];
    assign h12    = {3'b000, hour[4:0]};
    assign h24    = {2'b00, hour[5:0]};

    // Next hour value for each mode.
    always_comb begin
        if (mode12) begin
            if (h12 == 8'h11)      nxt = {2'b01, ~pm, 5'h12};
            else if (h12 == 8'h12) nxt = {2'b01, pm, 5'h01};
            else                   nxt = {2'b01, pm, 5'(bcd_inc(h12))};
        end else begin
            nxt = (h24 == 8'h23) ? 8'h00 : {2'b00, 6'(bcd_inc(h24))};
        end
    end

    // Hold, load or step the hour.
    always_ff @(posedge clk) begin
        if (!rst_n)    hour <= 8'h00;
        else if (wr)   hour <= wr_val & 8'h7F;
        else if (inc)  hour <= nxt;
    end

    // Midnight: 23 -> 00, or 11 PM -> 12 AM.
    assign carry = inc && !wr &&
                   (mode12 ? (pm && h12 == 8'h11) : (h24 == 8'h23));

endmodule

// File: rtl/bcd_rtc_core.sv
// Top of the BCD clock calendar: divider, counter chain, halt flag and host ports.
// Assumes host writes are legal BCD; illegal values are not corrected.
module bcd_rtc_core
    import rtc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_pulse,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data
);
    logic [NUM_FIELDS-1:0] wr_hit;
    logic       halt_q;
    logic       tick;
    logic [7:0] sec_v, min_v, hour_v, date_v, mon_v, year_v, date_hi;
    logic [2:0] dow_q;
    logic       c_sec, c_min, c_day, c_date, c_mon;

    // One write strobe per field.
    for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_hit
        assign wr_hit[k] = wr_en && (wr_addr == 3'(k));
    end

    // Halt flag, kept in bit 7 of the seconds byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                halt_q <= 1'b0;
        else if (wr_hit[FLD_SEC])  halt_q <= wr_data[7];
    end

    rtc_subsec_div #(.DIV(TICKS_PER_SEC)) u_div (
        .clk(clk), .rst_n(rst_n), .pulse(osc_pulse), .halt(halt_q),
        .clr(wr_hit[FLD_SEC]), .tick(tick)
    );

    rtc_bcd_wrap #(.RST(8'h00), .LO(8'h00), .MASK(8'h7F)) u_sec (
        .clk(clk), .rst_n(rst_n), .inc(tick), .hi(8'h59),
        .wr(wr_hit[FLD_SEC]), .wr_val(wr_data), .val(sec_v), .carry(c_sec)
    );

    rtc_bcd_wrap #(.RST(8'h00), .LO(8'h00), .MASK(8'h7F)) u_min (
        .clk(clk), .rst_n(rst_n), .inc(c_sec), .hi(8'h59),
        .wr(wr_hit[FLD_MIN]), .wr_val(wr_data), .val(min_v), .carry(c_min)
    );

    rtc_hour_ctr u_hour (
        .clk(clk), .rst_n(rst_n), .inc(c_min), .wr(wr_hit[FLD_HOUR]),
        .wr_val(wr_data), .hour(hour_v), .carry(c_day)
    );

    // Day of week: steps at midnight and wraps from 7 to 1.
    always_ff @(posedge clk) begin
        if (!rst_n)                 dow_q <= 3'd1;
        else if (wr_hit[FLD_DOW])   dow_q <= wr_data[2:0];
        else if (c_day)             dow_q <= (dow_q == 3'd7) ? 3'd1 : dow_q + 3'd1;
    end

    // The date limit follows the current month and year.
    assign date_hi = month_last(mon_v, year_v);

    rtc_bcd_wrap #(.RST(8'h01), .LO(8'h01), .MASK(8'h3F)) u_date (
        .clk(clk), .rst_n(rst_n), .inc(c_day), .hi(date_hi),
        .wr(wr_hit[FLD_DATE]), .wr_val(wr_data), .val(date_v), .carry(c_date)
    );

    rtc_bcd_wrap #(.RST(8'h01), .LO(8'h01), .MASK(8'h1F)) u_mon (
        .clk(clk), .rst_n(rst_n), .inc(c_date), .hi(8'h12),
        .wr(wr_hit[FLD_MON]), .wr_val(wr_data), .val(mon_v), .carry(c_mon)
    );

    // Two-digit year: wraps from 99 to 00.
    always_ff @(posedge clk) begin
        if (!rst_n)                 year_v <= 8'h00;
        else if (wr_hit[FLD_YEAR])  year_v <= wr_data;
        else if (c_mon)             year_v <= (year_v == 8'h99) ? 8'h00 : bcd_inc(year_v);
    end

    // Combinational read mux.
    always_comb begin
        case (rd_addr)
            FLD_SEC:  rd_data = sec_v | {halt_q, 7'b0};
            FLD_MIN:  rd_data = min_v;
            FLD_HOUR: rd_data = hour_v;
            FLD_DOW:  rd_data = {5'b0, dow_q};
            FLD_DATE: rd_data = date_v;
            FLD_MON:  rd_data = mon_v;
            FLD_YEAR: rd_data = year_v;
            default:  rd_data = 8'h00;
        endcase
    end

endmodule

// File: rtl/bcd_rtc_core_chk.sv
// Property checker for bcd_rtc_core, attached by bind below.
// Observes the tick, the carries and the field registers.
module bcd_rtc_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       halt,
    input logic       wr_en,
    input logic [2:0] wr_addr,
    input logic [7:0] wr_data,
    input logic [7:0] sec,
    input logic [7:0] min,
    input logic [7:0] hour,
    input logic [2:0] dow,
    input logic       c_min,
    input logic       c_day
);
    // R2: a halted clock never ticks.
    p_halt_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> !tick);

    // R1: seconds wrap from 59 to 00.
    p_sec_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && sec == 8'h59) |=> sec == 8'h00);

    // R3: the 24-hour count wraps at 23.
    p_midnight_24h_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_min && !wr_en && hour == 8'h23) |=> hour == 8'h00);

    // R4: 11 AM steps to 12 PM.
    p_noon_pm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (c_min && !wr_en && hour == 8'h51) |=> hour == 8'h72);

    // R6: the day of week wraps from 7 to 1 at midnight.
    p_dow_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (c_day && !wr_en && dow == 3'd7) |=> dow == 3'd1);

    // R9: a minutes write lands even when a carry arrives.
    p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd1) |=> min == {1'b0, $past(wr_data[6:0])});

endmodule

bind bcd_rtc_core bcd_rtc_core_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .halt(halt_q),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sec(sec_v), .min(min_v), .hour(hour_v), .dow(dow_q),
    .c_min(c_min), .c_day(c_day)
);

// File: tb/tb_bcd_rtc_core.sv
// Bench: an arithmetic model of the calendar, compared byte by byte after each step.
module tb_bcd_rtc_core;
    localparam int DIV = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_pulse = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    // Model state as plain integers.
    int s, m, h, pm, m12, dw, d, mo, y, hl;

    bcd_rtc_core #(.TICKS_PER_SEC(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .osc_pulse(osc_pulse), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) * 16) + (v % 10));
    endfunction

    function automatic int dim(input int mon, input int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] exp_byte(input int a);
        case (a)
            0: return (hl != 0 ? 8'h80 : 8'h00) | bcd(s);
            1: return bcd(m);
            2: return m12 != 0 ? (8'h40 | (pm != 0 ? 8'h20 : 8'h00) | bcd(h)) : bcd(h);
            3: return 8'(dw);
            4: return bcd(d);
            5: return bcd(mo);
            6: return bcd(y);
            default: return 8'h00;
        endcase
    endfunction

    // Advance the model by one second.
    task automatic adv();
        int day;
        if (hl != 0) return;
        day = 0;
        s++;
        if (s == 60) begin
            s = 0; m++;
            if (m == 60) begin
                m = 0;
                if (m12 != 0) begin
                    if (h == 11) begin h = 12; pm = 1 - pm; day = (pm == 0); end
                    else if (h == 12) h = 1;
                    else h++;
                end else begin
                    h++;
                    if (h == 24) begin h = 0; day = 1; end
                end
            end
        end
        if (day != 0) begin
            dw = (dw == 7) ? 1 : dw + 1;
            d++;
            if (d > dim(mo, y)) begin
                d = 1; mo++;
                if (mo == 13) begin mo = 1; y = (y + 1) % 100; end
            end
        end
    endtask

    // Compare all eight read addresses; call in the low clock phase.
    task automatic check_all(input string r);
        for (int a = 0; a < 8; a++) begin
            rd_addr = 3'(a);
            #1;
            checks++;
            if (rd_data !== exp_byte(a)) begin
                errors++;
                $display("FAIL %s addr %0d: actual %02h expected %02h", r, a, rd_data, exp_byte(a));
            end
        end
    endtask

    task automatic wr(input int a, input logic [7:0] dt);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = dt;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    // Load the model state; seconds last, which restarts the divider.
    task automatic load();
        osc_pulse = 1'b0;
        for (int a = 1; a < 7; a++) wr(a, exp_byte(a));
        wr(0, exp_byte(0));
    endtask

    task automatic ticks(input int n);
        @(negedge clk) osc_pulse = 1'b1;
        for (int i = 0; i < n; i++) begin
            repeat (DIV) @(posedge clk);
            adv();
        end
        @(negedge clk) osc_pulse = 1'b0;
    endtask

    task automatic set_time(input int hh, input int mm, input int ss);
        h = hh; m = mm; s = ss;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog: actual still running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        s = 0; m = 0; h = 0; pm = 0; m12 = 0; dw = 1; d = 1; mo = 1; y = 0; hl = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check_all("R10");

        // R1: one continuous hour, checked every tick.
        set_time(0, 0, 0); d = 14; mo = 6; y = 23; dw = 2;
        load();
        for (int i = 0; i < 3600; i++) begin
            ticks(1);
            check_all("R1");
        end

        // R3: every 24-hour value at the top of its hour.
        for (int hv = 0; hv < 24; hv++) begin
            m12 = 0; pm = 0; set_time(hv, 59, 59); d = 10; mo = 3; y = 5; dw = 4;
            load(); ticks(1); check_all("R3");
        end

        // R4: every 12-hour value, both AM and PM.
        for (int pv = 0; pv < 2; pv++) begin
            for (int hv = 1; hv < 13; hv++) begin
                m12 = 1; pm = pv; set_time(hv, 59, 59); d = 10; mo = 3; y = 5; dw = 4;
                load(); ticks(1); check_all("R4");
            end
        end

        // R6: day-of-week step and wrap at midnight.
        for (int dv = 1; dv < 8; dv++) begin
            m12 = 0; pm = 0; set_time(23, 59, 59); d = 5; mo = 7; y = 40; dw = dv;
            load(); ticks(1); check_all("R6");
        end

        // R5: last day of every month of every year, plus February 28.
        for (int yv = 0; yv < 100; yv++) begin
            for (int mv = 1; mv < 13; mv++) begin
                for (int v = 0; v < 2; v++) begin
                    if (v == 1 && mv != 2) continue;
                    m12 = 0; pm = 0; set_time(23, 59, 59); dw = 3; y = yv; mo = mv;
                    d = (v == 1) ? 28 : dim(mv, yv);
                    load(); ticks(1); check_all("R5");
                end
            end
        end

        // R2: halted clock stays still under oscillator pulses.
        m12 = 0; pm = 0; set_time(8, 30, 10); d = 2; mo = 2; y = 24; dw = 5; hl = 1;
        load();
        @(negedge clk) osc_pulse = 1'b1;
        repeat (4 * DIV) @(posedge clk);
        @(negedge clk) osc_pulse = 1'b0;
        check_all("R2");
        hl = 0;
        wr(0, exp_byte(0));
        ticks(1);
        check_all("R2");

        // R7: a seconds write restarts the divider mid-second.
        set_time(9, 0, 0); load();
        @(negedge clk) osc_pulse = 1'b1;
        repeat (DIV + 2) @(posedge clk);
        adv();
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h30;
        @(posedge clk);
        #1 wr_en = 1'b0;
        s = 30;
        repeat (DIV - 1) @(posedge clk);
        @(negedge clk);
        check_all("R7");
        @(posedge clk);
        adv();
        @(negedge clk) osc_pulse = 1'b0;
        check_all("R7");

        // R9: a minutes write collides with the seconds carry.
        set_time(10, 5, 59); load();
        @(negedge clk) osc_pulse = 1'b1;
        repeat (DIV - 1) @(posedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h33;
        @(posedge clk);
        #1 wr_en = 1'b0;
        s = 0; m = 33;
        @(negedge clk) osc_pulse = 1'b0;
        check_all("R9");

        // R8: reserved bits are dropped on write.
        wr(3, 8'hC5); wr(4, 8'hC7); wr(5, 8'hE9); wr(2, 8'h95);
        dw = 5; d = 7; mo = 9; h = 15; m12 = 0; pm = 0;
        @(negedge clk);
        check_all("R8");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule